// File: doc/BRIEF.md
# Predictive Duty Table Calculator

This block prepares, ahead of time, every duty value that a boost power-factor stage will use over the next half line period. A start strobe launches a fill. The block walks a rectified-sine table one switching period at a time. It reads each sample through an address output, and the sample comes back on the same cycle. From that sample it forms the instantaneous input voltage and the reference current, which is the peak-current command scaled by the sine sample. It then writes one duty value per period into a dual-port table that the PWM stage reads.

Each duty value is the sum of two terms. The voltage-balance term is one minus the ratio of instantaneous input voltage to output reference. The current-forcing term is proportional to the rise in reference current from this period to the next. The output reference enters as a precomputed reciprocal, so the divide becomes a multiply. No inductor-current feedback is used. The PWM stage has priority on the table. A busy input holds a pending write off until the port is free. The result is clamped before it is stored, and a one-cycle done pulse marks the end of the fill.

The controller has six states. IDLE waits for a start. LOAD takes the first sine sample. FETCH takes the sample for the following period. COMPUTE registers the clamped duty value. STORE writes it when the port is free. FINISH raises done. The transitions are as follows. IDLE goes to LOAD on start. LOAD goes to FETCH, FETCH to COMPUTE, and COMPUTE to STORE. STORE stays in STORE while the port is busy. Otherwise STORE goes to FETCH, or to FINISH after the last entry. FINISH returns to IDLE.

Top module: `dtc_duty_table_fill`

## Requirements
- R1: After reset, `tbl_wr_en` and `fill_done` are low and stay low until a start is accepted.
- R2: A fill writes exactly N_ENTRIES values, one per write, to addresses 0, 1, … N_ENTRIES-1 in ascending order.
- R3: With unsigned sine sample s(n) (SW fraction bits), the voltage term is computed as follows. First vin = (vin_peak·s(n))>>SW. Then ratio = (vin·vout_inv)>>CF. The unclamped duty is raw = 2^DW − ratio + cf(n), where 2^DW means a duty of one.
- R4: The current-forcing term is cf(n) = (cf_gain·(ir(n+1) − ir(n)))>>>CF with floor rounding, where ir(k) = (ipk_cmd·s(k))>>SW. For the final entry, the next sample is table entry 0.
- R5: While `pwm_busy` is high, no write is issued, and the pending address and data are held until a cycle with `pwm_busy` low.
- R6: A negative raw value is stored as 0. Otherwise, a raw value below duty_min is stored as duty_min, and one above duty_max is stored as duty_max.
- R7: `fill_done` is high for exactly one cycle, the cycle after the last write.
- R8: A start that arrives while a fill is running, or in the done cycle, has no effect.
- R9: All operand inputs are sampled when a start is accepted. Changes during a fill do not alter the values written.
- R10: The first write is offered 3 cycles after the edge that accepts start. Each following write is offered 3 cycles after the previous one, plus any cycles lost to `pwm_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_start | input | 1 | Start strobe for a half-line fill |
| vin_peak | input | VW | Peak input voltage |
| vout_inv | input | CW | Reciprocal of output reference, 2^(DW+CF)/Vref |
| ipk_cmd | input | IW | Peak reference current from the voltage loop |
| cf_gain | input | CW | Current-forcing gain, CF fraction bits |
| duty_min | input | DW+1 | Lower duty clamp |
| duty_max | input | DW+1 | Upper duty clamp |
| pwm_busy | input | 1 | PWM stage uses the table this cycle |
| sine_addr | output | AW | Sine table read address |
| sine_data | input | SW | Sine sample at sine_addr, same cycle |
| tbl_wr_en | output | 1 | Duty table write strobe |
| tbl_wr_addr | output | AW | Duty table write address |
| tbl_wr_data | output | DW+1 | Duty value written |
| fill_done | output | 1 | One-cycle end-of-fill pulse |

## Verification
The earliest result is a write strobe, offered three cycles after the edge that accepts start, and then every three cycles. Each one lags by one cycle for every cycle `pwm_busy` holds it. The done pulse comes in the cycle right after the last write. The bench keeps a countdown model that follows these latencies and reacts to the busy input it drives. It samples the outputs one time unit after each falling edge, once the combinational write strobe has settled against that cycle's busy. It then compares strobe, address, data and done against the model. The expected duty values are computed in integer arithmetic from the operands captured when start was accepted.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FETCH,
        ST_COMPUTE,
        ST_STORE,
        ST_FINISH
    } fill_state_t;
endpackage

// File: rtl/dtc_scale.sv
module dtc_scale #(
    parameter int MW = 12,
    parameter int SW = 12
) (
    input  logic [MW-1:0] mag,
    input  logic [SW-1:0] frac,
    output logic [MW-1:0] prod
);
    logic [MW+SW-1:0] full;

    assign full = {{SW{1'b0}}, mag} * {{MW{1'b0}}, frac};
    assign prod = full[MW+SW-1:SW];
endmodule

// File: rtl/dtc_duty.sv
module dtc_duty #(
    parameter int VW = 12,
    parameter int IW = 12,
    parameter int CW = 16,
    parameter int CF = 12,
    parameter int DW = 12
) (
    input  logic [VW-1:0] vin,
    input  logic [IW-1:0] ir_cur,
    input  logic [IW-1:0] ir_nxt,
    input  logic [CW-1:0] vo_inv,
    input  logic [CW-1:0] kcf,
    input  logic [DW:0]   dmin,
    input  logic [DW:0]   dmax,
    output logic [DW:0]   duty
);
    localparam int RW = CW + VW + IW + 3;

    logic [VW+CW-1:0]      rprod;
    logic signed [RW-1:0]  ratio_s;
    logic signed [RW-1:0]  diff_s;
    logic signed [RW-1:0]  cf_s;
    logic signed [RW-1:0]  raw_s;
    logic signed [RW-1:0]  one_s;

    assign rprod = {{CW{1'b0}}, vin} * {{VW{1'b0}}, vo_inv};

    always_comb begin
        one_s   = signed'(RW'(1)) <<< DW;
        ratio_s = signed'(RW'(rprod >> CF));
        diff_s  = signed'(RW'(ir_nxt)) - signed'(RW'(ir_cur));
        cf_s    = (diff_s * signed'(RW'(kcf))) >>> CF;
        raw_s   = one_s - ratio_s + cf_s;
        if (raw_s < 0)
            duty = '0;
        else if (raw_s < signed'(RW'(dmin)))
            duty = dmin;
        else if (raw_s > signed'(RW'(dmax)))
            duty = dmax;
        else
            duty = raw_s[DW:0];
    end
endmodule

// File: rtl/dtc_duty_table_fill.sv
module dtc_duty_table_fill
    import dtc_pkg::*;
#(
    parameter int N_ENTRIES = 1600,
    parameter int SW        = 12,
    parameter int VW        = 12,
    parameter int IW        = 12,
    parameter int CW        = 16,
    parameter int CF        = 12,
    parameter int DW        = 12,
    localparam int AW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_start,
    input  logic [VW-1:0] vin_peak,
    input  logic [CW-1:0] vout_inv,
    input  logic [IW-1:0] ipk_cmd,
    input  logic [CW-1:0] cf_gain,
    input  logic [DW:0]   duty_min,
    input  logic [DW:0]   duty_max,
    input  logic          pwm_busy,
    output logic [AW-1:0] sine_addr,
    input  logic [SW-1:0] sine_data,
    output logic          tbl_wr_en,
    output logic [AW-1:0] tbl_wr_addr,
    output logic [DW:0]   tbl_wr_data,
    output logic          fill_done
);
    localparam logic [AW-1:0] LAST = AW'(N_ENTRIES - 1);

    fill_state_t state, state_nx;

    logic [AW-1:0] idx, rd_addr;
    logic [SW-1:0] cur_s, nxt_s;
    logic [VW-1:0] vpk_q;
    logic [CW-1:0] voinv_q, kcf_q;
    logic [IW-1:0] ipk_q;
    logic [DW:0]   dmin_q, dmax_q, duty_q, duty_calc;
    logic [VW-1:0] vin_inst;
    logic [IW-1:0] ir_cur, ir_nxt;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] a);
        return (a == LAST) ? '0 : a + 1'b1;
    endfunction

    dtc_scale #(.MW(VW), .SW(SW)) u_vin   (.mag(vpk_q), .frac(cur_s), .prod(vin_inst));
    dtc_scale #(.MW(IW), .SW(SW)) u_irc   (.mag(ipk_q), .frac(cur_s), .prod(ir_cur));
    dtc_scale #(.MW(IW), .SW(SW)) u_irn   (.mag(ipk_q), .frac(nxt_s), .prod(ir_nxt));

    dtc_duty #(.VW(VW), .IW(IW), .CW(CW), .CF(CF), .DW(DW)) u_duty (
        .vin(vin_inst), .ir_cur(ir_cur), .ir_nxt(ir_nxt),
        .vo_inv(voinv_q), .kcf(kcf_q), .dmin(dmin_q), .dmax(dmax_q),
        .duty(duty_calc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (fill_start) state_nx = ST_LOAD;
            ST_LOAD:    state_nx = ST_FETCH;
            ST_FETCH:   state_nx = ST_COMPUTE;
            ST_COMPUTE: state_nx = ST_STORE;
            ST_STORE:   if (!pwm_busy) state_nx = (idx == LAST) ? ST_FINISH : ST_FETCH;
            ST_FINISH:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            rd_addr <= '0;
            cur_s   <= '0;
            nxt_s   <= '0;
            vpk_q   <= '0;
            voinv_q <= '0;
            kcf_q   <= '0;
            ipk_q   <= '0;
            dmin_q  <= '0;
            dmax_q  <= '0;
            duty_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (fill_start) begin
                    vpk_q   <= vin_peak;
                    voinv_q <= vout_inv;
                    ipk_q   <= ipk_cmd;
                    kcf_q   <= cf_gain;
                    dmin_q  <= duty_min;
                    dmax_q  <= duty_max;
                    idx     <= '0;
                    rd_addr <= '0;
                end
                ST_LOAD: begin
                    cur_s   <= sine_data;
                    rd_addr <= wrap_inc(rd_addr);
                end
                ST_FETCH:   nxt_s  <= sine_data;
                ST_COMPUTE: duty_q <= duty_calc;
                ST_STORE: if (!pwm_busy && idx != LAST) begin
                    idx     <= idx + 1'b1;
                    cur_s   <= nxt_s;
                    rd_addr <= wrap_inc(rd_addr);
                end
                ST_FINISH: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sine_addr   = rd_addr;
        tbl_wr_en   = (state == ST_STORE) && !pwm_busy;
        tbl_wr_addr = idx;
        tbl_wr_data = duty_q;
        fill_done   = (state == ST_FINISH);
    end
endmodule

// File: rtl/dtc_duty_table_fill_chk.sv
module dtc_duty_table_fill_chk
    import dtc_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 4,
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input fill_state_t   state,
    input logic          fill_start,
    input logic          pwm_busy,
    input logic          tbl_wr_en,
    input logic [AW-1:0] tbl_wr_addr,
    input logic [DW:0]   tbl_wr_data,
    input logic          fill_done,
    input logic [DW:0]   dmin_q,
    input logic [DW:0]   dmax_q
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && pwm_busy) |=>
            (state == ST_STORE && $stable(tbl_wr_addr) && $stable(tbl_wr_data)));

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr_en && tbl_wr_addr != LAST) |=>
            (tbl_wr_addr == AW'($past(tbl_wr_addr) + 1'b1)));

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> ($past(tbl_wr_en) && $past(tbl_wr_addr) == LAST));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);

    a_r6_clamp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr_en && dmin_q <= dmax_q) |->
            (tbl_wr_data == '0 || (tbl_wr_data >= dmin_q && tbl_wr_data <= dmax_q)));

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && fill_start) |=> (state != ST_LOAD));
endmodule

bind dtc_duty_table_fill dtc_duty_table_fill_chk #(.N(N_ENTRIES), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .fill_start(fill_start),
    .pwm_busy(pwm_busy), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_data(tbl_wr_data), .fill_done(fill_done),
    .dmin_q(dmin_q), .dmax_q(dmax_q)
);

// File: tb/dtc_duty_table_fill_test.sv
`timescale 1ns/1ps
module dtc_duty_table_fill_test;
    localparam int N  = 16;
    localparam int AW = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        fill_start = 0;
    logic [11:0] vin_peak = 0;
    logic [15:0] vout_inv = 0;
    logic [11:0] ipk_cmd = 0;
    logic [15:0] cf_gain = 0;
    logic [12:0] duty_min = 0;
    logic [12:0] duty_max = 0;
    logic        pwm_busy = 0;
    logic [AW-1:0] sine_addr;
    logic [11:0] sine_data;
    logic        tbl_wr_en;
    logic [AW-1:0] tbl_wr_addr;
    logic [12:0] tbl_wr_data;
    logic        fill_done;

    int lut [N];
    assign sine_data = 12'(lut[sine_addr]);

    always #5 clk = ~clk;

    dtc_duty_table_fill #(.N_ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .fill_start(fill_start),
        .vin_peak(vin_peak), .vout_inv(vout_inv), .ipk_cmd(ipk_cmd),
        .cf_gain(cf_gain), .duty_min(duty_min), .duty_max(duty_max),
        .pwm_busy(pwm_busy), .sine_addr(sine_addr), .sine_data(sine_data),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data), .fill_done(fill_done)
    );

    int checks = 0;
    int failures = 0;
    string data_tag = "R3";

    // behavioural model state
    bit     m_active = 0;
    bit     m_done = 0;
    int     m_wait = 0;
    int     m_idx = 0;
    longint m_exp [N];
    int     wr_count = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint exp_duty(int n);
        longint s, sn, vin, ratio, ir, irn, cf, raw;
        s     = lut[n];
        sn    = lut[(n + 1) % N];
        vin   = (longint'(vin_peak) * s) >> 12;
        ratio = (vin * longint'(vout_inv)) >> 12;
        ir    = (longint'(ipk_cmd) * s) >> 12;
        irn   = (longint'(ipk_cmd) * sn) >> 12;
        cf    = (longint'(cf_gain) * (irn - ir)) >>> 12;
        raw   = 4096 - ratio + cf;
        if (raw < 0) return 0;
        if (raw < longint'(duty_min)) return longint'(duty_min);
        if (raw > longint'(duty_max)) return longint'(duty_max);
        return raw;
    endfunction

    task automatic cyc(input bit st, input bit bz);
        bit exp_wr;
        @(negedge clk);
        fill_start = st;
        pwm_busy   = bz;
        #1;
        exp_wr = m_active && (m_wait == 0) && !bz;
        chk(tbl_wr_en == exp_wr, exp_wr ? "R10" : "R5", tbl_wr_en, exp_wr);
        if (exp_wr && tbl_wr_en) begin
            wr_count++;
            chk(tbl_wr_addr == AW'(m_idx), "R2", tbl_wr_addr, m_idx);
            chk(longint'(tbl_wr_data) == m_exp[m_idx], data_tag, tbl_wr_data, m_exp[m_idx]);
        end
        chk(fill_done == m_done, "R7", fill_done, m_done);
        // advance model to the next edge
        if (m_done) begin
            m_done = 0;
        end else if (!m_active) begin
            if (st) begin
                m_active = 1;
                m_wait   = 3;
                m_idx    = 0;
                for (int i = 0; i < N; i++) m_exp[i] = exp_duty(i);
            end
        end else if (m_wait > 0) begin
            m_wait--;
        end else if (!bz) begin
            if (m_idx == N - 1) begin
                m_active = 0;
                m_done   = 1;
            end else begin
                m_idx++;
                m_wait = 2;
            end
        end
    endtask

    // mode 0: free port, 1: busy pattern, 2: restart and operand changes mid-fill
    task automatic run_fill(input int mode);
        int k = 0;
        wr_count = 0;
        cyc(1, 0);
        while (m_active || m_done) begin
            bit st = 0, bz = 0;
            if (mode == 1) bz = (k % 3 == 0) || (k % 7 == 2);
            if (mode == 2) begin
                st = (k % 5 == 1) || m_done;
                if (k == 8) begin
                    vin_peak = 12'd3900; ipk_cmd = 12'd50; cf_gain = 16'd1;
                    duty_min = 13'd2000; duty_max = 13'd2100;
                end
            end
            cyc(st, bz);
            k++;
        end
        fill_start = 0;
        chk(wr_count == N, "R2", wr_count, N);
        cyc(0, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++)
            lut[i] = int'($floor(4095.0 * $sin(3.14159265 * (real'(i) + 0.5) / N)));
        repeat (3) @(negedge clk);
        #1;
        chk(tbl_wr_en == 0, "R1", tbl_wr_en, 0);
        chk(fill_done == 0, "R1", fill_done, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (3) cyc(0, 0);

        // nominal sine fill
        vin_peak = 12'd1500; vout_inv = 16'd8388; ipk_cmd = 12'd2000;
        cf_gain = 16'd6000; duty_min = 13'd0; duty_max = 13'd4096;
        data_tag = "R3";
        run_fill(0);

        // port contention
        data_tag = "R5";
        run_fill(1);

        // ramp table: final entry wraps to entry 0
        for (int i = 0; i < N; i++) lut[i] = 100 + 250 * i;
        cf_gain = 16'd20000;
        data_tag = "R4";
        run_fill(0);

        // clamping: negative, below minimum, above maximum
        for (int i = 0; i < N; i++)
            lut[i] = int'($floor(4095.0 * $sin(3.14159265 * (real'(i) + 0.5) / N)));
        vin_peak = 12'd4000; vout_inv = 16'd8388; ipk_cmd = 12'd1000;
        cf_gain = 16'd4000; duty_min = 13'd1000; duty_max = 13'd3000;
        data_tag = "R6";
        run_fill(1);

        // restart attempts and operand changes during a fill
        vin_peak = 12'd1200; ipk_cmd = 12'd1500; cf_gain = 16'd5000;
        duty_min = 13'd100; duty_max = 13'd4000;
        data_tag = "R9";
        run_fill(2);
        chk(fill_done == 0, "R8", fill_done, 0);
        repeat (4) cyc(0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule